// File: doc/BRIEF.md
# Converter Result Buffer with Fill Status

This block sits between a converter's result word and the output register. Each result word is 18 bits: bits [15:0] carry the conversion data, bit [16] a copy of the most significant bit and bit [17] the overflow flag. The block stores these words as whole words and does not interpret the bits. A mode input selects one of two paths. In bypass mode each finished conversion goes straight to the output. In buffered mode the words are queued in a 16-deep store. The oldest queued word is always present at the output, so a reader only needs to step through the rest.

In buffered mode a word is written on every end-of-conversion, whatever the read line is doing. Each rising edge on the read line steps the output to the next word. A falling edge on the read line while one word remains marks the buffer empty, and the last word stays on the output. Two status flags report the fill level. The read line is taken through a synchronizer inside the block. Holding both the mode and read lines low empties the buffer.

Top module: `conv_result_fifo`

## Requirements
- R1: When a word is written into an empty buffer in buffered mode (`fifoMode`=1), that word appears on `dataOut` without any read.
- R2: In bypass mode (`fifoMode`=0), every falling edge of `eocLine` loads `resultWord` into `dataOut`. Read edges and conversions leave the buffer contents and fill level unchanged.
- R3: In buffered mode, every falling edge of `eocLine` writes `resultWord` into the buffer when it holds fewer than 16 words, whether `readLine` is high or low.
- R4: The status flags encode the fill level as {`statHalf`,`statEdge`}: 0 words gives 01, 1 to 7 words give 00, 8 to 15 words give 10, and 16 words give 11.
- R5: In buffered mode, a rising edge on `readLine` while 2 or more words are held discards the oldest word and presents the next one. Fifteen such edges bring the 16th word of a full buffer to the output.
- R6: In buffered mode, a falling edge on `readLine` while exactly one word is held makes the buffer empty, and that word stays on `dataOut`.
- R7: While the buffer is empty in buffered mode, read edges leave `dataOut` unchanged and hold the last word shown.
- R8: A conversion that ends while 16 words are held is discarded, and the buffer keeps its 16 older words.
- R9: While `fifoMode` and the synchronized `readLine` are both low, the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoMode | input | 1 | 1 = buffered path, 0 = bypass path |
| readLine | input | 1 | Read strobe, asynchronous, idle high |
| eocLine | input | 1 | End-of-conversion level; a falling edge marks a finished result |
| resultWord | input | 18 | Result word {overflow, msb, data[15:0]} |
| dataOut | output | 18 | Word presented to the output register |
| statHalf | output | 1 | Status flag, high at 8 or more words |
| statEdge | output | 1 | Status flag, high when empty or full |

## Verification
The hardest case to reach from the ports is a full buffer drained to its end. That takes sixteen conversions, a seventeenth that must be lost, fifteen rising read edges, and then the falling edge that turns one remaining word into an empty buffer without changing the output. A directed sequence walks exactly this path and checks the status at 1, 7, 8, 15 and 16 words. A seeded random mix of conversions, read-line toggles and mode changes then lets writes happen with the read line low and lets clears happen halfway through a fill. Every result is compared against a queue model in the bench.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;
  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic wrEn;      // store resultWord at write pointer
    logic popEn;     // advance read pointer
    logic clrAll;    // return both pointers to zero
    logic dirLoad;   // load bypass register
    logic headValid; // at least one word is held
  } fifoStrobes_t;
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoMode,
  input  logic             readLine,
  input  logic             eocLine,
  output fifoStrobes_t     strobes,
  output logic [CNT_W-1:0] fillCount,
  output logic             statHalf,
  output logic             statEdge
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_CNT  = CNT_W'(2);

  logic [SYNC_STAGES:0] rdPipe;
  logic eocPrev;
  logic rdSync, rdPrev;
  logic eocFall, rdRise, rdFall;
  logic doWrite, doPop, doClear;
  logic [CNT_W-1:0] countNext;

  // Synchronizer plus one extra stage for edge detection; idle level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe  <= '1;
      eocPrev <= 1'b0;
    end else begin
      rdPipe  <= {rdPipe[SYNC_STAGES-1:0], readLine};
      eocPrev <= eocLine;
    end
  end

  assign rdSync  = rdPipe[SYNC_STAGES-1];
  assign rdPrev  = rdPipe[SYNC_STAGES];
  assign eocFall = eocPrev & ~eocLine;
  assign rdRise  = rdSync & ~rdPrev;
  assign rdFall  = ~rdSync & rdPrev;

  always_comb begin
    doClear = ~fifoMode & ~rdSync;
    doWrite = fifoMode & eocFall & (fillCount != FULL_CNT);
    doPop   = fifoMode & ((rdRise & (fillCount >= TWO_CNT)) |
                          (rdFall & (fillCount == ONE_CNT)));
    if (doClear)
      countNext = '0;
    else if (doWrite && !doPop)
      countNext = fillCount + ONE_CNT;
    else if (doPop && !doWrite)
      countNext = fillCount - ONE_CNT;
    else
      countNext = fillCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillCount <= '0;
    else       fillCount <= countNext;
  end

  always_comb begin
    strobes.wrEn      = doWrite;
    strobes.popEn     = doPop;
    strobes.clrAll    = doClear;
    strobes.dirLoad   = ~fifoMode & eocFall;
    strobes.headValid = (fillCount != '0);
  end

  assign statHalf = (fillCount >= HALF_CNT);
  assign statEdge = (fillCount == '0) | (fillCount == FULL_CNT);
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import conv_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] resultWord,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] directReg, lastWord, headWord;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrPtr] <= resultWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobes.clrAll) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.wrEn)  wrPtr <= wrPtr + PTR_W'(1);
      if (strobes.popEn) rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  assign headWord = store[rdPtr];

  // Holds the most recent head so an emptied buffer keeps showing it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWord  <= '0;
      directReg <= '0;
    end else begin
      if (strobes.headValid) lastWord  <= headWord;
      if (strobes.dirLoad)   directReg <= resultWord;
    end
  end

  always_comb begin
    if (!fifoMode)              dataOut = directReg;
    else if (strobes.headValid) dataOut = headWord;
    else                        dataOut = lastWord;
  end
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
  import conv_fifo_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              readLine,
  input  logic              eocLine,
  input  logic [DATA_W-1:0] resultWord,
  output logic [DATA_W-1:0] dataOut,
  output logic              statHalf,
  output logic              statEdge
);
  fifoStrobes_t     strobes;
  logic [CNT_W-1:0] fillCount;

  fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .readLine(readLine),
    .eocLine(eocLine), .strobes(strobes), .fillCount(fillCount),
    .statHalf(statHalf), .statEdge(statEdge)
  );

  fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .strobes(strobes),
    .resultWord(resultWord), .dataOut(dataOut)
  );
endmodule

// File: rtl/conv_fifo_checker.sv
module conv_fifo_checker #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoMode,
  input logic              readLine,
  input logic [DATA_W-1:0] dataOut,
  input logic [CNT_W-1:0]  fillCount
);
  // R8: the fill level never passes the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  // R2: bypass mode never adds words
  a_r2_bypass_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && $past(!fifoMode)) |-> fillCount <= $past(fillCount));

  // R3: at most one word is written per cycle
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= $past(fillCount) + CNT_W'(1));

  // R9: mode and read line held low long enough to pass the synchronizer
  a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && !readLine && $past(!fifoMode && !readLine) &&
     $past(!fifoMode && !readLine, 2) && $past(!fifoMode && !readLine, 3))
    |-> fillCount == '0);

  // R7: an empty buffer keeps its output still
  a_r7_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && $past(fifoMode) && fillCount == '0 && $past(fillCount) == '0)
    |-> $stable(dataOut));
endmodule

bind conv_result_fifo conv_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .readLine(readLine),
  .dataOut(dataOut), .fillCount(fillCount)
);

// File: tb/test_conv_result_fifo.sv
module test_conv_result_fifo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, fifoMode, readLine, eocLine;
  logic [17:0] resultWord, dataOut;
  logic        statHalf, statEdge;

  conv_result_fifo i_conv_result_fifo (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .readLine(readLine),
    .eocLine(eocLine), .resultWord(resultWord), .dataOut(dataOut),
    .statHalf(statHalf), .statEdge(statEdge)
  );

  int checks = 0;
  int failures = 0;
  logic [17:0] mq[$];
  logic [17:0] mLast = '0;
  logic [17:0] mDirect = '0;
  logic mMode = 1'b0;
  logic mRead = 1'b1;

  function automatic logic [17:0] expData();
    if (!mMode) return mDirect;
    if (mq.size() > 0) return mq[0];
    return mLast;
  endfunction

  function automatic logic [1:0] expStat();
    return {mq.size() >= 8, (mq.size() == 0) || (mq.size() == 16)};
  endfunction

  task automatic expectAll(string req);
    logic [17:0] ed;
    logic [1:0]  es;
    ed = expData();
    es = expStat();
    checks++;
    if (dataOut !== ed || {statHalf, statEdge} !== es) begin
      failures++;
      $display("FAIL %s: data=%h stat=%b expected data=%h stat=%b",
               req, dataOut, {statHalf, statEdge}, ed, es);
    end
  endtask

  task automatic updLast();
    if (mq.size() > 0) mLast = mq[0];
  endtask

  task automatic conv(logic [17:0] w, string req);
    @(negedge clk); resultWord = w; eocLine = 1'b1;
    @(negedge clk); eocLine = 1'b0;
    repeat (4) @(negedge clk);
    if (mMode) begin
      if (mq.size() < 16) mq.push_back(w);
    end else mDirect = w;
    updLast();
    expectAll(req);
  endtask

  task automatic setRead(logic v, string req);
    @(negedge clk); readLine = v;
    repeat (5) @(negedge clk);
    updLast();
    if (mMode) begin
      if (v && !mRead && mq.size() >= 2) void'(mq.pop_front());
      else if (!v && mRead && mq.size() == 1) void'(mq.pop_front());
    end
    mRead = v;
    if (!mMode && !mRead) mq.delete();
    updLast();
    expectAll(req);
  endtask

  task automatic setMode(logic v, string req);
    @(negedge clk); fifoMode = v;
    repeat (5) @(negedge clk);
    mMode = v;
    if (!mMode && !mRead) mq.delete();
    updLast();
    expectAll(req);
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; fifoMode = 1'b0; readLine = 1'b1; eocLine = 1'b0; resultWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectAll("R4 reset");

    // Bypass path and ignored reads
    conv(18'h12345, "R2 bypass load");
    setRead(1'b0, "R2 read ignored");
    setRead(1'b1, "R2 read ignored");
    conv(18'h2ABCD, "R2 bypass second");

    // Fill to full, check head and status boundaries
    setMode(1'b1, "R7 enter buffered empty");
    for (int i = 1; i <= 16; i++) conv(18'(i * 3 + 18'h10000), "R1 R3 R4 fill");
    conv(18'h3FFFF, "R8 full write lost");
    conv(18'h00001, "R8 later write lost");

    // Drain with fifteen rising edges, then falling edge empties
    setRead(1'b0, "R5 first fall no change");
    for (int i = 0; i < 15; i++) begin
      setRead(1'b1, "R5 rise steps");
      if (i < 14) setRead(1'b0, "R5 fall no change");
    end
    setRead(1'b0, "R6 final fall empties");
    setRead(1'b1, "R7 read when empty");
    setRead(1'b0, "R7 read when empty");

    // Writes with read line low, then clear through mode
    conv(18'h0AAAA, "R3 write with read low");
    conv(18'h05555, "R3 write with read low");
    setMode(1'b0, "R9 clear by mode and read");
    setMode(1'b1, "R9 buffer empty after clear");
    setRead(1'b1, "R7 idle high");

    // Seeded random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 500; n++) begin
      int unsigned r;
      r = $urandom % 12;
      if (r < 6)       conv(18'($urandom), "R3 random conversion");
      else if (r < 10) setRead(~mRead, "R5 random read edge");
      else             setMode(~mMode, "R9 random mode change");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule